// File: doc/BRIEF.md
# Layered Scan-Test Decompressor with Upward Tap Export

This block expands compressed scan-test stimulus for one core of a stacked-die system. A wide linear feedback shift register holds the expander state. On every scan shift cycle, each incoming compressed bit is XORed into its own state bit as the register shifts. Every scan-chain input of the local core is therefore a linear (XOR) combination of the compressed bits received since the last clear.

A few state bits are sent up the stack as tap outputs. Those taps become the compressed inputs of the same block one layer higher. Each layer exports fewer taps than it receives, so the channel count narrows toward the top of the stack. Compressed bits that one layer does not need can still serve a layer above it. Only taps cross between layers; scan chains stay local.

Between test cubes, a synchronous clear returns the state to all zeros. The block has no valid/ready handshake and no back-pressure. Scan shifting runs in lockstep across the whole stack, so the shift enable acts as the only data qualifier. A layer must never be stalled on its own.

Top module: `layer_decompressor`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, the state is zero, so `scan_out` and `tap_out` are all zeros.
- R2: With `shift_en` low and `cube_clr` low, the state holds at a clock edge, so `scan_out` and `tap_out` stay unchanged whatever `chan_in` carries.
- R3: With `shift_en` high and `cube_clr` low, the next state is computed in two steps. First, bit i takes old bit i-1 for i>0, and bit 0 takes the XOR of old bits 63, 62, 60 and 59. Then channel k is XORed into bit k*(STATE_W/IN_W).
- R4: A high `cube_clr` at a clock edge makes the state all zeros, whether `shift_en` is high or low.
- R5: Scan chain k equals state bit a XOR state bit (a+STATE_W/2+1) mod STATE_W, where a = k*(STATE_W/CHAINS). The output is taken from the current state, with no added register.
- R6: Tap j equals state bit (j*(STATE_W/TAP_W) + STATE_W/(2*TAP_W)) mod STATE_W, taken from the current state.
- R7: TAP_W must be smaller than IN_W. In a three-layer chain of widths 8, then 5, then 3, each upper layer consumes the lower layer's taps as its channels. The chain matches the per-layer rules R3 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Scan shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_en | input | 1 | Advance the state and inject channels this cycle |
| cube_clr | input | 1 | Synchronous clear between test cubes, dominant over shift_en |
| chan_in | input | IN_W | Compressed free-variable bits from the tester or the layer below |
| scan_out | output | CHAINS | Scan-chain inputs of the local core |
| tap_out | output | TAP_W | State bits exported to the layer above |

## Verification
The bench chains three layers and drives the bottom with random channel data. A behavioural model holding three 64-bit words is compared against every scan and tap output on every cycle. A wrong feedback tap or a misplaced injection bit diverges within a few shifts. An upper layer that sampled taps one cycle late would mismatch as soon as the lower taps change. Idle stretches with noisy channel data would expose a design that kept shifting or injecting without `shift_en`. A clear raised together with `shift_en` and live data catches a design that gave the shift priority. A directed single-bit injection pins one channel to one exact scan chain.

// File: rtl/decomp_pkg.sv
package decomp_pkg;

  // Evenly spread index idx of count over a vector of width bits, shifted by offset.
  function automatic int spread_pos(input int idx, input int count,
                                     input int width, input int offset);
    return (idx * (width / count) + offset) % width;
  endfunction

  // Second bit paired with a first bit in the phase spreader.
  function automatic int partner_pos(input int first, input int width);
    return (first + width / 2 + 1) % width;
  endfunction

endpackage

// File: rtl/chan_injector.sv
module chan_injector #(
  parameter int STATE_W = 64,
  parameter int IN_W    = 8
) (
  input  logic [IN_W-1:0]    chan_in,
  output logic [STATE_W-1:0] inj_vec
);
  import decomp_pkg::*;

  // Each channel lands on its own evenly spaced state bit.
  always_comb begin
    inj_vec = '0;
    for (int k = 0; k < IN_W; k++) begin
      inj_vec[spread_pos(k, IN_W, STATE_W, 0)] = chan_in[k];
    end
  end
endmodule

// File: rtl/lfsr_core.sv
module lfsr_core #(
  parameter int                STATE_W = 64,
  parameter logic [STATE_W-1:0] FB_MASK = 64'hD800_0000_0000_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               cube_clr,
  input  logic [STATE_W-1:0] inj_vec,
  output logic [STATE_W-1:0] state_q
);
  logic               fb_bit;
  logic [STATE_W-1:0] state_nx;

  always_comb begin
    fb_bit   = ^(state_q & FB_MASK);
    state_nx = {state_q[STATE_W-2:0], fb_bit} ^ inj_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= '0;
    else if (cube_clr) state_q <= '0;
    else if (shift_en) state_q <= state_nx;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cube_clr |=> (state_q == '0)); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !cube_clr) |=> $stable(state_q)); // R2

  AST_QUIET_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !cube_clr && inj_vec == '0)
      |=> (state_q[STATE_W-1:1] == $past(state_q[STATE_W-2:0]))); // R3
endmodule

// File: rtl/phase_spreader.sv
module phase_spreader #(
  parameter int STATE_W = 64,
  parameter int CHAINS  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_q,
  output logic [CHAINS-1:0]  scan_out
);
  import decomp_pkg::*;

  for (genvar k = 0; k < CHAINS; k++) begin : g_chain
    localparam int PA = spread_pos(k, CHAINS, STATE_W, 0);
    localparam int PB = partner_pos(PA, STATE_W);
    assign scan_out[k] = state_q[PA] ^ state_q[PB];
  end

  AST_SCAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0) |-> (scan_out == '0)); // R5
endmodule

// File: rtl/tap_picker.sv
module tap_picker #(
  parameter int STATE_W = 64,
  parameter int TAP_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state_q,
  output logic [TAP_W-1:0]   tap_out
);
  import decomp_pkg::*;

  localparam int TAP_OFS = STATE_W / (2 * TAP_W);

  for (genvar j = 0; j < TAP_W; j++) begin : g_tap
    assign tap_out[j] = state_q[spread_pos(j, TAP_W, STATE_W, TAP_OFS)];
  end

  AST_TAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == '0) |-> (tap_out == '0)); // R6
endmodule

// File: rtl/layer_decompressor.sv
module layer_decompressor #(
  parameter int                 STATE_W = 64,
  parameter int                 IN_W    = 8,
  parameter int                 TAP_W   = 5,
  parameter int                 CHAINS  = 16,
  parameter logic [STATE_W-1:0] FB_MASK = 64'hD800_0000_0000_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              cube_clr,
  input  logic [IN_W-1:0]   chan_in,
  output logic [CHAINS-1:0] scan_out,
  output logic [TAP_W-1:0]  tap_out
);
  logic [STATE_W-1:0] inj_vec;
  logic [STATE_W-1:0] state_q;

  // R7: the bandwidth must narrow going up the stack.
  if (TAP_W >= IN_W || IN_W > STATE_W || CHAINS > STATE_W) begin : g_bad_cfg
    $error("layer_decompressor: illegal width parameters");
  end

  chan_injector #(.STATE_W(STATE_W), .IN_W(IN_W)) u_inj (
    .chan_in (chan_in),
    .inj_vec (inj_vec)
  );

  lfsr_core #(.STATE_W(STATE_W), .FB_MASK(FB_MASK)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .cube_clr (cube_clr),
    .inj_vec  (inj_vec),
    .state_q  (state_q)
  );

  phase_spreader #(.STATE_W(STATE_W), .CHAINS(CHAINS)) u_spread (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_q  (state_q),
    .scan_out (scan_out)
  );

  tap_picker #(.STATE_W(STATE_W), .TAP_W(TAP_W)) u_taps (
    .clk     (clk),
    .rst_n   (rst_n),
    .state_q (state_q),
    .tap_out (tap_out)
  );

  AST_PORT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cube_clr |=> (scan_out == '0 && tap_out == '0)); // R4
endmodule

// File: tb/layer_decompressor_tb.sv
module layer_decompressor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shift_en = 1'b0;
  logic cube_clr = 1'b0;
  logic [7:0] chan_drv = '0;

  logic [15:0] scan0, scan1, scan2;
  logic [4:0]  tap0;
  logic [2:0]  tap1;
  logic [1:0]  tap2;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  layer_decompressor #(.IN_W(8), .TAP_W(5), .CHAINS(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cube_clr(cube_clr),
    .chan_in(chan_drv), .scan_out(scan0), .tap_out(tap0));

  layer_decompressor #(.IN_W(5), .TAP_W(3), .CHAINS(16)) mid_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cube_clr(cube_clr),
    .chan_in(tap0), .scan_out(scan1), .tap_out(tap1));

  layer_decompressor #(.IN_W(3), .TAP_W(2), .CHAINS(16)) top_i (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .cube_clr(cube_clr),
    .chan_in(tap1), .scan_out(scan2), .tap_out(tap2));

  // Behavioural reference: three 64-bit words.
  logic [63:0] m0 = '0, m1 = '0, m2 = '0;

  function automatic logic [63:0] step(input logic [63:0] s, input logic [63:0] inj);
    int fb_idx [4] = '{63, 62, 60, 59};
    logic fb = 1'b0;
    logic [63:0] r;
    foreach (fb_idx[i]) fb ^= s[fb_idx[i]];
    for (int i = 63; i > 0; i--) r[i] = s[i-1];
    r[0] = fb;
    return r ^ inj;
  endfunction

  function automatic logic [63:0] inject(input logic [7:0] ch, input int w);
    logic [63:0] v = '0;
    for (int k = 0; k < w; k++) v[(k * (64 / w)) % 64] ^= ch[k];
    return v;
  endfunction

  function automatic logic [7:0] taps(input logic [63:0] s, input int w);
    logic [7:0] t = '0;
    for (int j = 0; j < w; j++) t[j] = s[(j * (64 / w) + 64 / (2 * w)) % 64];
    return t;
  endfunction

  function automatic logic [15:0] scans(input logic [63:0] s);
    logic [15:0] c;
    for (int k = 0; k < 16; k++) c[k] = s[4 * k] ^ s[(4 * k + 33) % 64];
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n || cube_clr) begin
      m0 <= '0; m1 <= '0; m2 <= '0;
    end else if (shift_en) begin
      m0 <= step(m0, inject(chan_drv, 8));
      m1 <= step(m1, inject(taps(m0, 5), 5));
      m2 <= step(m2, inject(taps(m1, 3), 3));
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("scan L0", 64'(scan0), 64'(scans(m0)));
    chk("scan L1", 64'(scan1), 64'(scans(m1)));
    chk("scan L2", 64'(scan2), 64'(scans(m2)));
    chk("tap L0", 64'(tap0), 64'(taps(m0, 5)));
    chk("tap L1", 64'(tap1), 64'(taps(m1, 3)));
    chk("tap L2", 64'(tap2), 64'(taps(m2, 2)));
  endtask

  task automatic run(input int cycles, input int shift_pct, input int clr_pct);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      compare_all();
      shift_en = (($urandom % 100) < shift_pct);
      cube_clr = (($urandom % 1000) < clr_pct);
      chan_drv = 8'($urandom);
    end
  endtask

  initial begin
    // R1: reset state
    tag = "R1";
    repeat (3) @(negedge clk);
    compare_all();
    chk("zero scan at reset", 64'(scan0), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R3 R5 R6 R7: continuous random shifting through the chain
    tag = "R3 R5 R6 R7";
    run(400, 100, 0);

    // R2: idle with noisy channels
    tag = "R2";
    run(60, 0, 0);

    // R4: clear together with shift and live data
    tag = "R4";
    @(negedge clk);
    compare_all();
    shift_en = 1'b1; cube_clr = 1'b1; chan_drv = 8'hFF;
    @(negedge clk);
    compare_all();
    chk("scan L0 after clear", 64'(scan0), 64'h0);
    chk("tap L1 after clear", 64'(tap1), 64'h0);

    // R5: single channel bit 3 lands on state bit 24 -> chain 6 only
    tag = "R5";
    cube_clr = 1'b0; shift_en = 1'b1; chan_drv = 8'h08;
    @(negedge clk);
    shift_en = 1'b0; chan_drv = 8'h00;
    compare_all();
    chk("directed chain 6", 64'(scan0), 64'h0040);

    // R3 R4 R7: mixed traffic with sparse clears
    tag = "R3 R4 R7";
    run(3000, 70, 15);

    // R2 R4: clear while idle
    tag = "R2 R4";
    run(200, 20, 60);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule